// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block collects 64 interrupt request lines into two 32-bit banks and drives one interrupt line to the processor. Every input passes through a synchronizer. Lines of the edge type are captured into a sticky event register on a rising edge and stay there until software clears them. Lines of the level type are never captured: they raise a request only while they are high. Each bank has its own enable mask. The processor line is high when any enabled bit in either bank is pending.

Software reaches the banks through a simple 32-bit port that decodes a 4 KB window. Each write takes a one-cycle strobe. Read data comes back one clock after the read strobe. A bank returns three values on reads: the captured events, the mask and the live synchronized levels. A mask write replaces the enable set. A clear write drops the event bits written as one, except on lines of the level type.

Top module: `irqc_top`

## Requirements
- R1: After reset, every bank register reads zero and irqOut is 0.
- R2: Input line k is routed to bank 1 bit k for k < 32, and to bank 0 bit k-32 for k >= 32.
- R3: A rising edge on an edge-type line sets its event bit, and the bit stays set after the line falls. The level register (offset 0xC) shows the synchronized input, which lags the pin by three clocks.
- R4: Bank 1 bits 20 to 28 (constant 0x1FF00000) are level-type; bank 0 has none. A level-type line never sets an event bit, and clear writes do not affect it.
- R5: A write to bank offset 0x8 clears exactly the event bits given as 1 in the write data, and leaves the other event bits unchanged.
- R6: A bank requests service when ((events | (levels & levelType)) & mask) is nonzero. irqOut is the registered OR of both banks' requests and follows the register state one clock later.
- R7: Bank 0 is decoded at 0x010-0x01F and bank 1 at 0x020-0x02F. Reads at any other address return 0, and writes there change nothing.
- R8: Within a bank, offset 0x0 reads the events, 0x4 reads and writes the mask, and 0xC reads the levels. Other read offsets return 0. Writes to 0x0 and 0xC have no effect.
- R9: When a rising edge and a clear of the same event bit land in the same clock, the bit ends up set.
- R10: rdData holds the addressed value on the clock after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 64 | Raw interrupt request lines |
| wrEn | input | 1 | One-cycle write strobe |
| rdEn | input | 1 | One-cycle read strobe |
| addr | input | 12 | Byte offset inside the 4 KB window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one clock after rdEn |
| irqOut | output | 1 | Interrupt line to the processor |

## Verification
Two operations can hit the same event bit in the same clock: the edge capture from a synchronized input and a software clear. To make them coincide, the bench raises a line and counts the two synchronizer stages, then asserts the clear strobe so that its clock edge is the one on which the edge is seen. The result is correct if the bit reads back as set. A second line is cleared one clock later as a control, and that bit must read back as zero. This shows that the outcome depends on the clear arriving in the same cycle as the capture, and not on the clear being ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_EVENT = 2'd1,
    RD_MASK  = 2'd2,
    RD_LEVEL = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   maskWr;
    logic   clearWr;
    logic   bankSel;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] bankIdx;
  logic [3:0]       regOff;
  logic             bankHit;

  assign bankIdx = addr[ADDR_W-1:4];
  assign regOff  = addr[3:0];
  assign bankHit = (bankIdx >= IDX_W'(1)) && (bankIdx <= IDX_W'(NUM_BANKS));

  always_comb begin
    strobe         = '0;
    strobe.bankSel = (bankIdx == IDX_W'(2));
    strobe.rdEn    = rdEn;
    strobe.maskWr  = wrEn && bankHit && (regOff == 4'h4);
    strobe.clearWr = wrEn && bankHit && (regOff == 4'h8);
    strobe.rdSel   = RD_NONE;
    if (bankHit) begin
      unique case (regOff)
        4'h0:    strobe.rdSel = RD_EVENT;
        4'h4:    strobe.rdSel = RD_MASK;
        4'hC:    strobe.rdSel = RD_LEVEL;
        default: strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_TYPE = 64'h1FF00000_00000000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_BANKS*BANK_W-1:0]          irqIn,
  input  logic [BANK_W-1:0]                    wrData,
  input  ctrlStrobe_t                          strobe,
  output logic [BANK_W-1:0]                    rdData,
  output logic                                 irqOut,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]     evState,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]     mskState
);
  localparam int NUM_LINES = NUM_BANKS * BANK_W;

  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0]                  syncd;
  logic [NUM_BANKS-1:0][BANK_W-1:0]      lvlState;
  logic [NUM_BANKS-1:0]                  bankReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign syncd = syncQ[SYNC_STAGES-1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [BANK_W-1:0] LVL_TYPE = LEVEL_TYPE[b*BANK_W +: BANK_W];

    logic [BANK_W-1:0] lineNow, prevQ, evQ, mskQ, lvlQ, riseSet, clrBits;
    logic              bankHit;

    assign lineNow = syncd[(NUM_BANKS-1-b)*BANK_W +: BANK_W];
    assign bankHit = (int'(strobe.bankSel) == b);
    assign riseSet = lineNow & ~prevQ & ~LVL_TYPE;
    assign clrBits = (strobe.clearWr && bankHit) ? (wrData & ~LVL_TYPE) : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevQ <= '0;
        evQ   <= '0;
        mskQ  <= '0;
        lvlQ  <= '0;
      end else begin
        prevQ <= lineNow;
        lvlQ  <= lineNow;
        evQ   <= (evQ & ~clrBits) | riseSet;
        if (strobe.maskWr && bankHit) mskQ <= wrData;
      end
    end

    assign bankReq[b]  = |((evQ | (lvlQ & LVL_TYPE)) & mskQ);
    assign evState[b]  = evQ;
    assign mskState[b] = mskQ;
    assign lvlState[b] = lvlQ;
  end

  logic [BANK_W-1:0] rdMux;
  always_comb begin
    unique case (strobe.rdSel)
      RD_EVENT: rdMux = evState[strobe.bankSel];
      RD_MASK:  rdMux = mskState[strobe.bankSel];
      RD_LEVEL: rdMux = lvlState[strobe.bankSel];
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      irqOut <= 1'b0;
    end else begin
      irqOut <= |bankReq;
      if (strobe.rdEn) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wrData,
  output logic [BANK_W-1:0]           rdData,
  output logic                        irqOut
);
  ctrlStrobe_t                      strobe;
  logic [NUM_BANKS-1:0][BANK_W-1:0] evState;
  logic [NUM_BANKS-1:0][BANK_W-1:0] mskState;

  irqc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  irqc_datapath #(.BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .wrData   (wrData),
    .strobe   (strobe),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .evState  (evState),
    .mskState (mskState)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int BANK_W = 32,
  parameter logic [31:0] LVL1 = 32'h1FF00000
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [11:0]            addr,
  input logic [BANK_W-1:0]      wrData,
  input logic [BANK_W-1:0]      rdData,
  input logic                   irqOut,
  input logic [1:0][BANK_W-1:0] evState,
  input logic [1:0][BANK_W-1:0] mskState
);
  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 12'h014) |=> (mskState[0] == $past(wrData)));

  // R4
  level_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evState[1] & LVL1) == '0));

  // R5
  ev0_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(evState[0]) & ~evState[0])) |-> $past(wrEn && addr == 12'h018));

  // R5
  ev1_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(evState[1]) & ~evState[1])) |-> $past(wrEn && addr == 12'h028));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mskState == '0) |=> !irqOut);

  // R7
  low_index_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[11:4] == 8'h00) |=> (rdData == '0));

  // R10
  mask_read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == 12'h014) |=> (rdData == $past(mskState[0])));
endmodule

bind irqc_top irqc_chk uChk (.*);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irqc_top u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    chk(req, rdData, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irqOut", {31'b0, irqOut}, 0);
    rdChk("R1 ev0", 12'h010, 0);
    rdChk("R1 mask0", 12'h014, 0);
    rdChk("R1 lvl1", 12'h02C, 0);
    rdChk("R1 ev1", 12'h020, 0);
  endtask

  task automatic t_edge();
    @(negedge clk); irqIn[40] = 1'b1;
    idle(5);
    rdChk("R3 lvl0 high", 12'h01C, 32'h100);
    @(negedge clk); irqIn[40] = 1'b0;
    idle(5);
    rdChk("R2 R3 ev0 sticky", 12'h010, 32'h100);
    rdChk("R3 lvl0 low", 12'h01C, 0);
    rdChk("R2 ev1 untouched", 12'h020, 0);
    chk("R6 masked off", {31'b0, irqOut}, 0);
    @(negedge clk); irqIn[3] = 1'b1;
    idle(5);
    @(negedge clk); irqIn[3] = 1'b0;
    rdChk("R2 line3 bank1", 12'h020, 32'h8);
  endtask

  task automatic t_mask();
    wr(12'h014, 32'h100);
    rdChk("R8 mask0 readback", 12'h014, 32'h100);
    chk("R6 irq on", {31'b0, irqOut}, 1);
    wr(12'h014, 32'h0);
    idle(1);
    chk("R6 irq off", {31'b0, irqOut}, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); irqIn[41] = 1'b1;
    idle(5);
    @(negedge clk); irqIn[41] = 1'b0;
    wr(12'h018, 32'h100);
    rdChk("R5 partial clear", 12'h010, 32'h200);
    wr(12'h018, 32'hFFFF_FFFF);
    rdChk("R5 full clear", 12'h010, 0);
    wr(12'h028, 32'h8);
    rdChk("R5 bank1 clear", 12'h020, 0);
  endtask

  task automatic t_level();
    @(negedge clk); irqIn[20] = 1'b1;
    idle(5);
    rdChk("R4 no event", 12'h020, 0);
    rdChk("R3 lvl1 bit20", 12'h02C, 32'h0010_0000);
    wr(12'h024, 32'h0010_0000);
    idle(1);
    chk("R6 level irq", {31'b0, irqOut}, 1);
    wr(12'h028, 32'hFFFF_FFFF);
    idle(1);
    chk("R4 clear ignored", {31'b0, irqOut}, 1);
    @(negedge clk); irqIn[20] = 1'b0;
    idle(5);
    chk("R6 level drop", {31'b0, irqOut}, 0);
    wr(12'h024, 32'h0);
  endtask

  task automatic t_decode();
    wr(12'h034, 32'hFFFF);
    wr(12'h004, 32'hFFFF);
    rdChk("R7 mask0 intact", 12'h014, 0);
    rdChk("R7 mask1 intact", 12'h024, 0);
    rdChk("R7 idx2 read", 12'h034, 0);
    rdChk("R7 low read", 12'h004, 0);
    wr(12'h010, 32'hFFFF);
    wr(12'h01C, 32'hFFFF);
    rdChk("R8 ev write ignored", 12'h010, 0);
    rdChk("R8 lvl write ignored", 12'h01C, 0);
    wr(12'h024, 32'hA5A5_0000);
    rdChk("R8 offset8 reads 0", 12'h028, 0);
    rdChk("R10 mask1 latency", 12'h024, 32'hA5A5_0000);
    wr(12'h024, 32'h0);
  endtask

  task automatic t_race();
    @(negedge clk); irqIn[41] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 12'h018; wrData = 32'h200;
    @(negedge clk); wrEn = 1'b0;
    rdChk("R9 set wins", 12'h010, 32'h200);
    @(negedge clk); irqIn[42] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 12'h018; wrData = 32'h400;
    @(negedge clk); wrEn = 1'b0;
    rdChk("R9 later clear", 12'h010, 32'h200);
    @(negedge clk); irqIn[42:41] = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_edge();
    t_mask();
    t_clear();
    t_level();
    t_decode();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule